// File: doc/BRIEF.md
# Watchdog Reset-Cause Register with Reload Unlock Guard

This block keeps a byte-wide status register that records why the device last came out of reset or out of stop mode. Four flags are kept: power-on, stop-mode recovery, watchdog expiry and external reset pin. Software reads the register to learn the cause. Every read of the status address returns the flags as they stood and then clears them. Writes to the status address never change a flag.

The same status address also serves as a key port for a bank of three reload bytes. Together these bytes form the 24-bit time-out period handed to a separate watchdog counter. The bank accepts writes only after the key 0x55 and then the key 0xAA arrive at the status address. After that it takes exactly one write to each byte, upper first, and then locks itself again.

The register bus is a plain strobe interface with address, write strobe, read strobe and byte data in each direction. It has no valid/ready handshake and no back-pressure. Every strobe completes in the cycle it is asserted, and read data is combinational from the address. The four event inputs are single-cycle pulses from the reset and power controller. The power-on reset is the block's asynchronous active-low reset.

Top module: `wdt_cause_guard`

## Requirements
- R1: While and after the power-on reset `rst_n` is low, the status register reads 0x80 and `reload_value` is 0xFFFFFF.
- R2: The status byte holds the power-on flag in bit 7, the stop-recovery flag in bit 6, the watchdog-expiry flag in bit 5 and the external-reset flag in bit 4. Bits 3 to 0 always read 0. Status lives at address 0x0; the reload upper, high and low bytes live at 0x1, 0x2 and 0x3. Any other address reads 0x00.
- R3: A read of the status address (`bus_rd`=1) returns the current flags in that cycle and clears all four flags on the following edge. An event pulse in the same cycle as the read wins: the flag it sets reads 1 afterwards.
- R4: A write to the status address never changes any status flag, whatever the data.
- R5: The power-on flag is cleared by any watchdog expiry (`ev_wdt_run` or `ev_stop_wdt`) or by any stop recovery (`ev_stop_pin` or `ev_stop_wdt`). Only the power-on reset sets it.
- R6: The stop flag is set by a stop recovery of either cause (`ev_stop_pin` or `ev_stop_wdt`). It is cleared by a watchdog expiry outside stop mode (`ev_wdt_run`).
- R7: The watchdog flag is set by an expiry in either mode (`ev_wdt_run` or `ev_stop_wdt`). It is cleared by a stop recovery from an input pin (`ev_stop_pin`). When a stop recovery comes from a watchdog expiry (`ev_stop_wdt`), both the stop flag and the watchdog flag read 1.
- R8: The external-reset flag is set by `ev_ext` and cleared by `ev_stop_pin`. When a set and a clear of the same flag fall in one cycle, the set wins.
- R9: The reload bank opens when two consecutive bus writes are 0x55 and then 0xAA, both to the status address. Reads in between are allowed. Once open, it accepts one write to 0x1, then one to 0x2, then one to 0x3. After the write to 0x3 it locks again.
- R10: Once 0x55 has been written, the next bus write returns the guard to locked unless that write is 0xAA to the status address. While the bank is open, a write to the status address locks it again without touching any reload byte.
- R11: A reload-byte write is ignored while the bank is locked, and also while it is open but the write goes to a byte other than the next one expected.
- R12: `reload_value` is {upper, high, low}. Each reload byte reads back at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ev_stop_pin | input | 1 | Stop-mode recovery caused by an input pin change (pulse) |
| ev_stop_wdt | input | 1 | Stop-mode recovery caused by a watchdog expiry (pulse) |
| ev_wdt_run | input | 1 | Watchdog expiry outside stop mode (pulse) |
| ev_ext | input | 1 | Reset caused by the external reset pin (pulse) |
| reload_value | output | 24 | Watchdog time-out period, {upper, high, low} |

## Verification
The hardest states to reach are the edges of the unlock sequence. These are a broken key pair, a status write in the middle of an open window, a write to the wrong reload byte, and a status read that coincides with an event pulse. Directed sequences drive each of these cases and then check that `reload_value` and the read-back bytes did not move. A long mixed phase then applies random strobes to all five addresses, with data biased toward the two key values and sparse event pulses. A behavioural model follows the guard and the flags, and its result is compared with the design on every clock.

// File: rtl/wdcu_pkg.sv
package wdcu_pkg;

  // flag vector positions inside the 4-bit cause vector
  localparam int FLG_POR  = 3;
  localparam int FLG_STOP = 2;
  localparam int FLG_WDT  = 1;
  localparam int FLG_EXT  = 0;
  localparam int NFLAGS   = 4;

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_ARMED  = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_state_t;

  typedef struct packed {
    logic stop_pin;
    logic stop_wdt;
    logic wdt_run;
    logic ext;
  } cause_events_t;

endpackage

// File: rtl/wdcu_cause_flags.sv
module wdcu_cause_flags
  import wdcu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  cause_events_t       ev,
  input  logic                clr_rd,
  output logic [NFLAGS-1:0]   flags
);

  localparam logic [NFLAGS-1:0] FLAG_RST = NFLAGS'(1) << FLG_POR;

  logic [NFLAGS-1:0] set_v;
  logic [NFLAGS-1:0] clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    // power-on flag: only the reset sets it
    clr_v[FLG_POR]  = ev.stop_pin | ev.stop_wdt | ev.wdt_run | clr_rd;
    // stop recovery flag
    set_v[FLG_STOP] = ev.stop_pin | ev.stop_wdt;
    clr_v[FLG_STOP] = ev.wdt_run | clr_rd;
    // watchdog expiry flag
    set_v[FLG_WDT]  = ev.wdt_run | ev.stop_wdt;
    clr_v[FLG_WDT]  = ev.stop_pin | clr_rd;
    // external pin flag
    set_v[FLG_EXT]  = ev.ext;
    clr_v[FLG_EXT]  = ev.stop_pin | clr_rd;
  end

  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[f] <= FLAG_RST[f];
      end else if (set_v[f]) begin
        flags[f] <= 1'b1;
      end else if (clr_v[f]) begin
        flags[f] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdcu_unlock_seq.sv
module wdcu_unlock_seq
  import wdcu_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          NBYTES   = 3,
  parameter logic [7:0]  KEY_ARM  = 8'h55,
  parameter logic [7:0]  KEY_OPEN = 8'hAA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               hit_status,
  input  logic [NBYTES-1:0]  hit_byte,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NBYTES-1:0]  byte_we,
  output logic               is_open
);

  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NBYTES - 1);

  unlock_state_t     state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              take_byte;

  assign is_open = (state_q == UL_OPEN);

  // one write enable per byte; byte index 0 is the low byte,
  // the window walks from the top index down to 0
  for (genvar k = 0; k < NBYTES; k++) begin : g_we
    assign byte_we[k] = is_open & wr_en & hit_byte[k] & (idx_q == IDX_W'(k));
  end

  assign take_byte = |byte_we;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      UL_LOCKED: begin
        if (wr_en && hit_status && (wr_data == DATA_W'(KEY_ARM))) begin
          state_d = UL_ARMED;
        end
      end
      UL_ARMED: begin
        if (wr_en) begin
          if (hit_status && (wr_data == DATA_W'(KEY_OPEN))) begin
            state_d = UL_OPEN;
            idx_d   = IDX_TOP;
          end else begin
            state_d = UL_LOCKED;
          end
        end
      end
      UL_OPEN: begin
        if (wr_en && hit_status) begin
          state_d = UL_LOCKED;
        end else if (take_byte) begin
          if (idx_q == '0) begin
            state_d = UL_LOCKED;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
      end
      default: state_d = UL_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UL_LOCKED;
      idx_q   <= IDX_TOP;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/wdcu_reload_bank.sv
module wdcu_reload_bank #(
  parameter int          DATA_W   = 8,
  parameter int          NBYTES   = 3,
  parameter logic [7:0]  RST_BYTE = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NBYTES-1:0]         byte_we,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NBYTES*DATA_W-1:0]  bytes_q
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[k*DATA_W +: DATA_W] <= DATA_W'(RST_BYTE);
      end else if (byte_we[k]) begin
        bytes_q[k*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/wdt_cause_guard.sv
module wdt_cause_guard
  import wdcu_pkg::*;
#(
  parameter int          ADDR_W       = 4,
  parameter int          DATA_W       = 8,
  parameter int          NBYTES       = 3,
  parameter int          ADDR_STATUS  = 0,
  parameter int          ADDR_RLD_TOP = 1,
  parameter logic [7:0]  KEY_ARM      = 8'h55,
  parameter logic [7:0]  KEY_OPEN     = 8'hAA,
  parameter logic [7:0]  RLD_RST_BYTE = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      ev_stop_pin,
  input  logic                      ev_stop_wdt,
  input  logic                      ev_wdt_run,
  input  logic                      ev_ext,
  output logic [NBYTES*DATA_W-1:0]  reload_value
);

  localparam int                RLD_W  = NBYTES * DATA_W;
  localparam int                PAD_W  = DATA_W - NFLAGS;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(ADDR_STATUS);

  logic                hit_status;
  logic [NBYTES-1:0]   hit_byte;
  logic [NFLAGS-1:0]   flags;
  logic [NBYTES-1:0]   byte_we;
  logic                rld_open;
  logic [RLD_W-1:0]    rld_bytes;
  cause_events_t       ev;

  assign ev.stop_pin = ev_stop_pin;
  assign ev.stop_wdt = ev_stop_wdt;
  assign ev.wdt_run  = ev_wdt_run;
  assign ev.ext      = ev_ext;

  assign hit_status = (bus_addr == STAT_A);

  // byte k (0 = low) sits at ADDR_RLD_TOP + (NBYTES-1-k): upper byte first
  for (genvar k = 0; k < NBYTES; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] BYTE_A = ADDR_W'(ADDR_RLD_TOP + NBYTES - 1 - k);
    assign hit_byte[k] = (bus_addr == BYTE_A);
  end

  wdcu_cause_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .clr_rd (bus_rd & hit_status),
    .flags  (flags)
  );

  wdcu_unlock_seq #(
    .DATA_W   (DATA_W),
    .NBYTES   (NBYTES),
    .KEY_ARM  (KEY_ARM),
    .KEY_OPEN (KEY_OPEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .hit_status (hit_status),
    .hit_byte   (hit_byte),
    .wr_data    (bus_wdata),
    .byte_we    (byte_we),
    .is_open    (rld_open)
  );

  wdcu_reload_bank #(
    .DATA_W   (DATA_W),
    .NBYTES   (NBYTES),
    .RST_BYTE (RLD_RST_BYTE)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (byte_we),
    .wr_data (bus_wdata),
    .bytes_q (rld_bytes)
  );

  assign reload_value = rld_bytes;

  always_comb begin
    bus_rdata = '0;
    if (hit_status) begin
      bus_rdata = {flags, {PAD_W{1'b0}}};
    end
    for (int k = 0; k < NBYTES; k++) begin
      if (hit_byte[k]) begin
        bus_rdata = rld_bytes[k*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/wdt_cause_guard_chk.sv
module wdt_cause_guard_chk #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NBYTES      = 3,
  parameter int ADDR_STATUS = 0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic                      ev_stop_pin,
  input logic                      ev_stop_wdt,
  input logic                      ev_wdt_run,
  input logic                      ev_ext,
  input logic [3:0]                flags,
  input logic [NBYTES-1:0]         byte_we,
  input logic                      rld_open,
  input logic [NBYTES*DATA_W-1:0]  reload_value
);

  logic quiet;
  logic at_status;
  assign quiet     = !(ev_stop_pin || ev_stop_wdt || ev_wdt_run || ev_ext);
  assign at_status = (bus_addr == ADDR_W'(ADDR_STATUS));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_status && quiet) |=> (flags == 4'b0000));

  // R4
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_status && !bus_rd && quiet) |=> $stable(flags));

  // R5
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_pin || ev_stop_wdt || ev_wdt_run) |=> !flags[3]);

  // R6
  stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_pin || ev_stop_wdt) |=> flags[2]);

  // R7
  wdt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_run || ev_stop_wdt) |=> flags[1]);

  // R9
  one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_we));

  // R10
  open_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_open && bus_wr && at_status) |=> !rld_open);

  // R11
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_open |=> $stable(reload_value));

endmodule

bind wdt_cause_guard wdt_cause_guard_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .NBYTES      (NBYTES),
  .ADDR_STATUS (ADDR_STATUS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .ev_stop_pin  (ev_stop_pin),
  .ev_stop_wdt  (ev_stop_wdt),
  .ev_wdt_run   (ev_wdt_run),
  .ev_ext       (ev_ext),
  .flags        (flags),
  .byte_we      (byte_we),
  .rld_open     (rld_open),
  .reload_value (reload_value)
);

// File: tb/sim_wdt_cause_guard.sv
`timescale 1ns/1ps
module sim_wdt_cause_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ev_stop_pin = 1'b0;
  logic        ev_stop_wdt = 1'b0;
  logic        ev_wdt_run = 1'b0;
  logic        ev_ext = 1'b0;
  logic [23:0] reload_value;

  always #4 clk = ~clk;

  wdt_cause_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_stop_pin(ev_stop_pin), .ev_stop_wdt(ev_stop_wdt),
    .ev_wdt_run(ev_wdt_run), .ev_ext(ev_ext), .reload_value(reload_value)
  );

  // behavioural reference
  int m_por, m_stp, m_wdt, m_ext;
  int m_rld[3];      // [0]=upper [1]=high [2]=low
  int m_state;       // 0 locked, 1 armed, 2 open
  int m_next;        // next byte position in the open window
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic int model_read(int a);
    if (a == 0) return (m_por << 7) | (m_stp << 6) | (m_wdt << 5) | (m_ext << 4);
    if (a >= 1 && a <= 3) return m_rld[a-1];
    return 0;
  endfunction

  task automatic model_reset();
    m_por = 1; m_stp = 0; m_wdt = 0; m_ext = 0;
    for (int i = 0; i < 3; i++) m_rld[i] = 8'hFF;
    m_state = 0; m_next = 0;
  endtask

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; ev = {stop_pin, stop_wdt, wdt_run, ext}
  task automatic step(string tag, int a, bit wr, bit rd, int d, logic [3:0] ev);
    bit sp, sw, wr_run, ex, clrrd;
    @(negedge clk);
    bus_addr = 4'(a); bus_wr = wr; bus_rd = rd; bus_wdata = 8'(d);
    {ev_stop_pin, ev_stop_wdt, ev_wdt_run, ev_ext} = ev;
    #1;
    if (rd) check(tag, int'(bus_rdata), model_read(a));
    check("R12 reload_value", int'(reload_value), (m_rld[0] << 16) | (m_rld[1] << 8) | m_rld[2]);
    {sp, sw, wr_run, ex} = ev;
    clrrd = rd && (a == 0);
    if (sp || sw || wr_run || clrrd) m_por = 0;
    if (sp || sw) m_stp = 1; else if (wr_run || clrrd) m_stp = 0;
    if (wr_run || sw) m_wdt = 1; else if (sp || clrrd) m_wdt = 0;
    if (ex) m_ext = 1; else if (sp || clrrd) m_ext = 0;
    if (wr) begin
      case (m_state)
        0: if (a == 0 && d == 8'h55) m_state = 1;
        1: begin
          m_state = (a == 0 && d == 8'hAA) ? 2 : 0;
          m_next = 0;
        end
        default: begin
          if (a == 0) m_state = 0;
          else if (a == 1 + m_next) begin
            m_rld[m_next] = d;
            m_next++;
            if (m_next == 3) m_state = 0;
          end
        end
      endcase
    end
  endtask

  task automatic idle();
    step("R1", 0, 0, 0, 0, 4'b0000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; {ev_stop_pin, ev_stop_wdt, ev_wdt_run, ev_ext} = '0;
    model_reset();
    #1;
    check("R1 status in reset", int'(bus_rdata), 8'h80);
    check("R1 reload in reset", int'(reload_value), 24'hFFFFFF);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd_status(string tag);
    step(tag, 0, 0, 1, 0, 4'b0000);
  endtask

  task automatic wr(string tag, int a, int d);
    step(tag, a, 1, 0, d, 4'b0000);
  endtask

  task automatic open_bank();
    wr("R9 key1", 0, 8'h55);
    wr("R9 key2", 0, 8'hAA);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    // R1, R2, R3: power-on value, then cleared by the read
    rd_status("R1 first read");
    rd_status("R3 after clear");
    // R4: status write data never lands in the flags
    do_reset();
    wr("R4 write ff", 0, 8'hFF);
    wr("R4 write 0f", 0, 8'h0F);
    rd_status("R4 flags unchanged");
    // R5 R7: run-mode expiry
    do_reset();
    step("R7", 0, 0, 0, 0, 4'b0010);
    rd_status("R5 R7 run expiry");
    // R6 R7: stop recovery from watchdog
    do_reset();
    step("R6", 0, 0, 0, 0, 4'b0100);
    rd_status("R6 R7 stop by wdt");
    // R8 then pin recovery clears ext/wdt, sets stop
    do_reset();
    step("R8", 0, 0, 0, 0, 4'b0001);
    rd_status("R8 ext set");
    step("R8", 0, 0, 0, 0, 4'b0001);
    step("R7", 0, 0, 0, 0, 4'b0010);
    step("R8", 0, 0, 0, 0, 4'b1000);
    rd_status("R8 pin recovery");
    step("R6", 0, 0, 0, 0, 4'b1000);
    step("R6", 0, 0, 0, 0, 4'b0011);
    rd_status("R6 stop cleared by run expiry");
    // R8: set beats clear in one cycle
    step("R8", 0, 0, 0, 0, 4'b1011);
    rd_status("R8 set wins");
    // R3: read and event together
    step("R3 read with event", 0, 0, 1, 0, 4'b0001);
    rd_status("R3 event survives read");
    rd_status("R3 cleared");
    // R9 R12: full unlock and reload
    do_reset();
    open_bank();
    wr("R9 upper", 1, 8'h12);
    wr("R9 high", 2, 8'h34);
    wr("R9 low", 3, 8'h56);
    step("R12 read upper", 1, 0, 1, 0, 4'b0000);
    step("R12 read high", 2, 0, 1, 0, 4'b0000);
    step("R12 read low", 3, 0, 1, 0, 4'b0000);
    step("R2 unmapped", 7, 0, 1, 0, 4'b0000);
    // R11: relocked after low byte
    wr("R11 locked write", 1, 8'h99);
    wr("R11 locked write", 3, 8'h99);
    // R10: broken key pair
    wr("R10", 0, 8'h55);
    wr("R10 bad key", 0, 8'h00);
    wr("R10", 0, 8'hAA);
    wr("R10 still locked", 1, 8'h77);
    wr("R10", 0, 8'h55);
    wr("R10 key at wrong addr", 1, 8'hAA);
    wr("R10 still locked", 1, 8'h77);
    // R9: reads between keys do not break the sequence
    wr("R9", 0, 8'h55);
    rd_status("R9 read between keys");
    wr("R9", 0, 8'hAA);
    // R11: out-of-order byte ignored while open
    wr("R11 out of order", 3, 8'hEE);
    wr("R11 out of order", 2, 8'hEE);
    wr("R9 upper", 1, 8'hA1);
    wr("R11 repeat upper", 1, 8'hB2);
    // R10: status write aborts the window
    wr("R10 abort", 0, 8'h00);
    wr("R10 after abort", 2, 8'hC3);
    idle();
    // mixed random phase
    for (int i = 0; i < 600; i++) begin
      int a, d, r;
      logic [3:0] e;
      a = $urandom_range(0, 4);
      r = $urandom_range(0, 9);
      d = (r < 3) ? 8'h55 : (r < 6) ? 8'hAA : $urandom_range(0, 255);
      e = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'b0000;
      r = $urandom_range(0, 2);
      step("R2 mixed", a, r == 1, r == 2, d, e);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule